// File: doc/BRIEF.md
# Joinable Dual PWM Channel

This block holds two pulse-width channels of `CW` bits each, a lower channel (0) and an upper channel (1). Each channel has a period, a duty, an output polarity, an enable, a choice between two single-cycle clock enables and a choice between edge-aligned and centre-aligned counting. Each channel drives one output bit. When the join input is high, the two channels act as one channel of `2*CW` bits. The upper port supplies the high half of the period and duty, and the lower port supplies the low half. The upper channel's control bits govern this joined channel, and the result appears on `pwm_out[1]`.

Each channel's period and duty are copied into internal working copies. While a channel is disabled, the copy is refreshed on every clock. While it runs, the copy is refreshed only when the counter returns to zero. This lets software change the settings without producing a torn cycle. Zero duty, zero period and duty at or above the period each give a steady output.

The upper output also has an emergency-shutdown watch. When it is armed and the shutdown input sits at its active level, the upper output is forced to a chosen safe level. Edges on the input, or arming while the input is already active, set a sticky flag. That flag drives the only interrupt of the block, gated by an interrupt enable.

Top module: `pwm_pair`

## Requirements
- R1: After reset both outputs, `sd_flag` and `irq` are 0, both counters are at zero and counting up, and no counter advances until its channel is enabled.
- R2: In edge-aligned mode (`ch_center[i]`=0), an enabled channel's counter advances once per selected tick from 0 to P-1 and then wraps to 0. The output equals `ch_pol[i]` while the counter is below the duty D and equals its inverse otherwise.
- R3: In centre-aligned mode (`ch_center[i]`=1), the counter runs 0,1..P and then P-1..1,0, so one cycle lasts 2P ticks. The output equals `ch_pol[i]` while the counter is below D, so it changes where the count meets D on the way up and on the way down.
- R4: With D=0 and P>0, the output is held at the inverse of `ch_pol[i]`.
- R5: With P=0, the counter stays at 0 and the output is held at `ch_pol[i]`.
- R6: With D>=P and P>0, the output is held at `ch_pol[i]`.
- R7: A running channel takes new period and duty values only when its counter returns to 0. A disabled channel takes them on every clock. A channel whose working period is 0 takes them on every selected tick.
- R8: When `pair_join`=1, the counter is `2*CW` bits wide, with P={`per_hi`,`per_lo`} and D={`duty_hi`,`duty_lo`}. The bits `ch_en[1]`, `ch_pol[1]`, `ch_csel[1]` and `ch_center[1]` control it, the result drives `pwm_out[1]`, and `pwm_out[0]` is held at 0.
- R9: A channel advances only on clock cycles where its selected enable is high: `clk_en_a` when `ch_csel[i]`=0, `clk_en_b` when `ch_csel[i]`=1.
- R10: A disabled channel drives 0, and its counter returns to 0 counting up.
- R11: `sd_in` passes through two flops, a sampling stage and a history stage. With `sd_mon_en`=1, `sd_flag` sets one cycle after the sampling stage sees an edge. It also sets when `sd_mon_en` rises while the sampled level equals `sd_act_lvl`.
- R12: `irq` is 1 exactly when `sd_flag` is 1 and `irq_en` is 1.
- R13: A one-cycle `irq_clr` pulse clears `sd_flag` on the next clock, unless a setting event occurs in the same cycle; in that case the flag stays set.
- R14: While `sd_mon_en`=1 and the sampled shutdown level equals `sd_act_lvl`, `pwm_out[1]` equals `sd_safe_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_a | input | 1 | Tick source chosen when clock-select is 0 |
| clk_en_b | input | 1 | Tick source chosen when clock-select is 1 |
| pair_join | input | 1 | Join both channels into one wide channel |
| ch_en | input | 2 | Per-channel enable |
| ch_pol | input | 2 | Per-channel active level |
| ch_csel | input | 2 | Per-channel tick source select |
| ch_center | input | 2 | Per-channel centre-aligned mode |
| per_lo | input | CW | Period of channel 0 / low half when joined |
| per_hi | input | CW | Period of channel 1 / high half when joined |
| duty_lo | input | CW | Duty of channel 0 / low half when joined |
| duty_hi | input | CW | Duty of channel 1 / high half when joined |
| sd_in | input | 1 | Emergency-shutdown input |
| sd_mon_en | input | 1 | Arms the shutdown watch |
| sd_act_lvl | input | 1 | Active level of the shutdown input |
| sd_safe_lvl | input | 1 | Level forced on `pwm_out[1]` during shutdown |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear pulse for the flag |
| pwm_out | output | 2 | Channel outputs |
| sd_flag | output | 1 | Sticky shutdown flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default `CW`=8. At this width, 8-bit periods of 5 to 7 ticks show many full edge-aligned and centre-aligned cycles in a few dozen clocks. The joined channel then has a period of 300, which needs the upper half, so a carry across the two halves is exercised within a few hundred cycles. The divide-by-three pattern on `clk_en_b` shows the effect of the tick select, and toggling `sd_in` exercises every flag-set and flag-clear ordering.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/pwm_pair_cnt.sv
// Counter with working copies of period and duty for one channel.
module pwm_pair_cnt
  import pwm_pair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         center,
  input  logic [W-1:0] per_in,
  input  logic [W-1:0] duty_in,
  output logic [W-1:0] cnt,
  output logic [W-1:0] bper,
  output logic [W-1:0] bduty
);
  cnt_dir_e    dir;
  logic [W:0]  cnt_inc;

  assign cnt_inc = {1'b0, cnt} + {{W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      dir   <= CNT_UP;
      bper  <= '0;
      bduty <= '0;
    end else if (!en) begin
      cnt   <= '0;
      dir   <= CNT_UP;
      bper  <= per_in;
      bduty <= duty_in;
    end else if (tick) begin
      if (bper == '0) begin
        cnt   <= '0;
        dir   <= CNT_UP;
        bper  <= per_in;
        bduty <= duty_in;
      end else if (!center) begin
        dir <= CNT_UP;
        if (cnt_inc >= {1'b0, bper}) begin
          cnt   <= '0;
          bper  <= per_in;
          bduty <= duty_in;
        end else begin
          cnt <= cnt_inc[W-1:0];
        end
      end else if (dir == CNT_UP) begin
        if (cnt_inc >= {1'b0, bper}) begin
          cnt <= bper;
          dir <= CNT_DOWN;
        end else begin
          cnt <= cnt_inc[W-1:0];
        end
      end else begin
        if (cnt <= W'(1)) begin
          cnt   <= '0;
          dir   <= CNT_UP;
          bper  <= per_in;
          bduty <= duty_in;
        end else begin
          cnt <= cnt - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pwm_pair_wave.sv
// Output level from count and working values, including steady cases.
module pwm_pair_wave #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic         pol,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] bper,
  input  logic [W-1:0] bduty,
  output logic         wave
);
  always_comb begin
    if (!en)                wave = 1'b0;
    else if (bper == '0)    wave = pol;
    else if (bduty >= bper) wave = pol;
    else if (cnt < bduty)   wave = pol;
    else                    wave = ~pol;
  end
endmodule

// File: rtl/pwm_pair_sdn.sv
// Shutdown watch: sampling, edge/arming detection, sticky flag.
module pwm_pair_sdn (
  input  logic clk,
  input  logic rst_n,
  input  logic sd_in,
  input  logic mon_en,
  input  logic act_lvl,
  input  logic clr,
  output logic flag,
  output logic force_safe
);
  logic smp, hist, mon_q, set_evt;

  assign set_evt    = mon_en && ((smp != hist) || (!mon_q && (smp == act_lvl)));
  assign force_safe = mon_en && (smp == act_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp   <= 1'b0;
      hist  <= 1'b0;
      mon_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      smp   <= sd_in;
      hist  <= smp;
      mon_q <= mon_en;
      if (set_evt)  flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_a,
  input  logic          clk_en_b,
  input  logic          pair_join,
  input  logic [1:0]    ch_en,
  input  logic [1:0]    ch_pol,
  input  logic [1:0]    ch_csel,
  input  logic [1:0]    ch_center,
  input  logic [CW-1:0] per_lo,
  input  logic [CW-1:0] per_hi,
  input  logic [CW-1:0] duty_lo,
  input  logic [CW-1:0] duty_hi,
  input  logic          sd_in,
  input  logic          sd_mon_en,
  input  logic          sd_act_lvl,
  input  logic          sd_safe_lvl,
  input  logic          irq_en,
  input  logic          irq_clr,
  output logic [1:0]    pwm_out,
  output logic          sd_flag,
  output logic          irq
);
  localparam int DW = 2 * CW;

  logic [1:0]    en_eff;
  logic [1:0]    wave;
  logic [DW-1:0] per_sel  [2];
  logic [DW-1:0] duty_sel [2];
  logic [CW-1:0] cnt0, bper0;
  logic          sd_force;

  assign en_eff[0]   = ch_en[0] & ~pair_join;
  assign en_eff[1]   = ch_en[1];
  assign per_sel[0]  = DW'(per_lo);
  assign duty_sel[0] = DW'(duty_lo);
  assign per_sel[1]  = pair_join ? {per_hi, per_lo}   : DW'(per_hi);
  assign duty_sel[1] = pair_join ? {duty_hi, duty_lo} : DW'(duty_hi);

  for (genvar gi = 0; gi < 2; gi++) begin : g_ch
    localparam int W = (gi == 1) ? DW : CW;
    logic [W-1:0] cnt_l, bper_l, bduty_l;
    logic         tick_l;

    assign tick_l = ch_csel[gi] ? clk_en_b : clk_en_a;

    pwm_pair_cnt #(.W(W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_eff[gi]),
      .tick    (tick_l),
      .center  (ch_center[gi]),
      .per_in  (per_sel[gi][W-1:0]),
      .duty_in (duty_sel[gi][W-1:0]),
      .cnt     (cnt_l),
      .bper    (bper_l),
      .bduty   (bduty_l)
    );

    pwm_pair_wave #(.W(W)) u_wave (
      .en    (en_eff[gi]),
      .pol   (ch_pol[gi]),
      .cnt   (cnt_l),
      .bper  (bper_l),
      .bduty (bduty_l),
      .wave  (wave[gi])
    );

    if (gi == 0) begin : g_tap
      assign cnt0  = cnt_l;
      assign bper0 = bper_l;
    end
  end

  pwm_pair_sdn u_sdn (
    .clk        (clk),
    .rst_n      (rst_n),
    .sd_in      (sd_in),
    .mon_en     (sd_mon_en),
    .act_lvl    (sd_act_lvl),
    .clr        (irq_clr),
    .flag       (sd_flag),
    .force_safe (sd_force)
  );

  assign pwm_out[0] = wave[0];
  assign pwm_out[1] = sd_force ? sd_safe_lvl : wave[1];
  assign irq        = sd_flag & irq_en;
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    ch_en,
  input logic          pair_join,
  input logic [1:0]    pwm_out,
  input logic          irq_en,
  input logic          irq,
  input logic          sd_flag,
  input logic          irq_clr,
  input logic          sd_force,
  input logic          sd_safe_lvl,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] bper0
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R12
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en[0] |-> !pwm_out[0]); // R10
  AST_JOIN_LOWER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pair_join |-> !pwm_out[0]); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_flag && !irq_clr) |=> sd_flag); // R13
  AST_ZERO_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bper0 == '0) |-> (cnt0 == '0)); // R5
  AST_SAFE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    sd_force |-> (pwm_out[1] == sd_safe_lvl)); // R14
endmodule

bind pwm_pair pwm_pair_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ch_en       (ch_en),
  .pair_join   (pair_join),
  .pwm_out     (pwm_out),
  .irq_en      (irq_en),
  .irq         (irq),
  .sd_flag     (sd_flag),
  .irq_clr     (irq_clr),
  .sd_force    (sd_force),
  .sd_safe_lvl (sd_safe_lvl),
  .cnt0        (cnt0),
  .bper0       (bper0)
);

// File: tb/pwm_pair_tb.sv
module pwm_pair_tb;
  localparam int CW    = 8;
  localparam int CLK_P = 10;
  localparam int SCALE = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en_a = 1'b1, clk_en_b = 1'b0, pair_join = 1'b0;
  logic [1:0]    ch_en = '0, ch_pol = '0, ch_csel = '0, ch_center = '0;
  logic [CW-1:0] per_lo = '0, per_hi = '0, duty_lo = '0, duty_hi = '0;
  logic          sd_in = 1'b0, sd_mon_en = 1'b0, sd_act_lvl = 1'b1;
  logic          sd_safe_lvl = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic [1:0]    pwm_out;
  logic          sd_flag, irq;

  int    errors = 0, checks = 0, div = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference state
  int m_cnt[2], m_dir[2], m_bp[2], m_bd[2];
  bit m_smp, m_hist, m_monq, m_flag;

  always #(CLK_P/2) clk = ~clk;

  pwm_pair #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_a(clk_en_a), .clk_en_b(clk_en_b),
    .pair_join(pair_join), .ch_en(ch_en), .ch_pol(ch_pol), .ch_csel(ch_csel),
    .ch_center(ch_center), .per_lo(per_lo), .per_hi(per_hi),
    .duty_lo(duty_lo), .duty_hi(duty_hi), .sd_in(sd_in),
    .sd_mon_en(sd_mon_en), .sd_act_lvl(sd_act_lvl),
    .sd_safe_lvl(sd_safe_lvl), .irq_en(irq_en), .irq_clr(irq_clr),
    .pwm_out(pwm_out), .sd_flag(sd_flag), .irq(irq)
  );

  // R9: clk_en_b pulses once every three clocks
  always @(negedge clk) begin
    div      <= (div == 2) ? 0 : div + 1;
    clk_en_b <= (div == 2);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_dir[i] = 0; m_bp[i] = 0; m_bd[i] = 0;
      end
      m_smp = 0; m_hist = 0; m_monq = 0; m_flag = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit en, tk, ctr;
        int pin, din;
        en  = (i == 0) ? (ch_en[0] && !pair_join) : ch_en[1];
        tk  = ch_csel[i] ? clk_en_b : clk_en_a;
        ctr = ch_center[i];
        if (i == 0) begin
          pin = per_lo; din = duty_lo;
        end else if (pair_join) begin
          pin = per_hi * SCALE + per_lo; din = duty_hi * SCALE + duty_lo;
        end else begin
          pin = per_hi; din = duty_hi;
        end
        if (!en || (tk && m_bp[i] == 0)) begin
          m_cnt[i] = 0; m_dir[i] = 0; m_bp[i] = pin; m_bd[i] = din;
        end else if (tk) begin
          if (!ctr) begin
            m_dir[i] = 0;
            if (m_cnt[i] + 1 >= m_bp[i]) begin
              m_cnt[i] = 0; m_bp[i] = pin; m_bd[i] = din;
            end else m_cnt[i]++;
          end else if (m_dir[i] == 0) begin
            if (m_cnt[i] + 1 >= m_bp[i]) begin
              m_cnt[i] = m_bp[i]; m_dir[i] = 1;
            end else m_cnt[i]++;
          end else if (m_cnt[i] <= 1) begin
            m_cnt[i] = 0; m_dir[i] = 0; m_bp[i] = pin; m_bd[i] = din;
          end else m_cnt[i]--;
        end
      end
      if (sd_mon_en && ((m_smp != m_hist) || (!m_monq && m_smp == sd_act_lvl)))
        m_flag = 1;
      else if (irq_clr)
        m_flag = 0;
      m_hist = m_smp; m_smp = sd_in; m_monq = sd_mon_en;
    end
  end

  function automatic bit exp_wave(int i);
    bit en, pol;
    en  = (i == 0) ? (ch_en[0] && !pair_join) : ch_en[1];
    pol = ch_pol[i];
    if (!en) return 0;
    if (m_bp[i] == 0 || m_bd[i] >= m_bp[i]) return pol;
    return (m_cnt[i] < m_bd[i]) ? pol : !pol;
  endfunction

  task automatic check(string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%0b expected=%0b", tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit e1;
    #(CLK_P/4);
    if (!done) begin
      e1 = (sd_mon_en && m_smp == sd_act_lvl) ? sd_safe_lvl : exp_wave(1);
      check("pwm_out[0]", pwm_out[0], exp_wave(0));
      check("pwm_out[1]", pwm_out[1], e1);
      check("sd_flag", sd_flag, m_flag);
      check("irq", irq, m_flag && irq_en);
    end
  end

  task automatic run(string t, int n);
    tag = t;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    run("R1", 4);
    rst_n = 1'b1;
    run("R1", 3);
    // R2: edge-aligned on both channels
    per_lo = 5; duty_lo = 2; per_hi = 7; duty_hi = 3;
    ch_pol = 2'b01; ch_en = 2'b11;
    run("R2", 40);
    // R7: change while running
    per_lo = 6; duty_lo = 4; duty_hi = 5;
    run("R7", 30);
    // R3: centre-aligned, restarted through disable
    ch_en = 2'b00;
    run("R10", 3);
    ch_center = 2'b11; ch_en = 2'b11;
    run("R3", 50);
    // R4, R6, R5 steady cases
    duty_lo = 0; duty_hi = 0;
    run("R4", 30);
    duty_lo = 6; duty_hi = 9;
    run("R6", 30);
    per_lo = 0; per_hi = 0;
    run("R5", 20);
    per_lo = 5; duty_lo = 3; per_hi = 4; duty_hi = 1; ch_center = 2'b00;
    run("R7", 20);
    // R9: slow tick on channel 1
    ch_csel = 2'b10;
    run("R9", 60);
    ch_en[0] = 1'b0;
    run("R10", 10);
    // R8: joined 16-bit, period 300, duty 128
    ch_en = 2'b11; ch_csel = 2'b00; ch_pol = 2'b01;
    per_hi = 1; per_lo = 8'h2C; duty_hi = 0; duty_lo = 8'h80;
    pair_join = 1'b1;
    run("R8", 650);
    ch_center[1] = 1'b1; ch_en[1] = 1'b0;
    run("R8", 2);
    ch_en[1] = 1'b1; ch_pol[1] = 1'b1;
    run("R8", 620);
    pair_join = 1'b0; ch_center = 2'b00; per_hi = 6; duty_hi = 2; per_lo = 5; duty_lo = 2;
    run("R2", 10);
    // R11, R12, R14: shutdown watch
    sd_mon_en = 1'b1; sd_safe_lvl = 1'b1; sd_act_lvl = 1'b1;
    run("R11", 5);
    sd_in = 1'b1;
    run("R14", 6);
    irq_en = 1'b1;
    run("R12", 4);
    irq_clr = 1'b1;
    run("R13", 1);
    irq_clr = 1'b0;
    run("R13", 3);
    // R13: clear coincides with an edge
    sd_in = 1'b0;
    run("R11", 1);
    irq_clr = 1'b1;
    run("R13", 1);
    irq_clr = 1'b0;
    run("R13", 4);
    irq_clr = 1'b1;
    run("R13", 1);
    irq_clr = 1'b0;
    // R11: arming while already active
    sd_mon_en = 1'b0; sd_in = 1'b1;
    run("R11", 5);
    sd_mon_en = 1'b1;
    run("R11", 5);
    irq_en = 1'b0;
    run("R12", 3);
    sd_act_lvl = 1'b0; sd_safe_lvl = 1'b0;
    run("R14", 10);
    finish_run();
  end
endmodule